// File: doc/BRIEF.md
# Variable-Length Half-Slot Prefix Decoder

This block reads the per-half-slot prefix codes that a block header supplies for a 256-bit instruction block made of variable-length instructions, each a multiple of 16 bits long. Here the header, not the instruction bits, marks where every instruction begins. For short instructions it also supplies the leading bits that do not fit in the 16 bits of the half-slot. For each of up to 14 half-slots the decoder reports four things: whether an instruction starts there, which kind of instruction it is, the reconstructed leading bits, and a break flag for parallel issue.

The meaning of the 3-bit prefix codes depends on a 2-bit mode value. When headers use up part of the block, fewer half-slots remain than there are prefix fields. The fields are aligned to the right: field 0 always describes the rightmost half-slot. The only block data the decoder inspects is the three most significant bits of each half-slot. Those bits separate a normal 32-bit start from an instruction of 48 bits or more. A parameter selects a combinational output or one output register stage.

Top module: `hsd_prefix_decoder`

## Requirements
- R1: Half-slot k (k = 0 is the rightmost) is described by prefix field `pfx_i[3k+2:3k]` and by leading bits `msb_i[3k+2:3k]`. Half-slots with k >= `remain_i` report start 0, kind 0, lead 0 and break 0. A count above 14 acts as 14.
- R2: Outputs per half-slot are `start_o[k]`, `kind_o[3k+2:3k]`, `lead_o[2k+1:2k]` and `brk_o[k]`. Kind codes are: 0 none, 1 short17, 2 augmented short, 3 normal 32-bit, 4 alternate 32-bit, 5 wide33, 6 short18, 7 long (48 bits or more). `start_o[k]` is 1 exactly when the kind is nonzero.
- R3: In mode 00, the codes map as follows. 000 and 001 give kind 1 with lead {0, code[0]}. 010 gives kind 2. 011 gives kind 0. 101 gives kind 4. 110 and 111 give kind 5 with lead {0, code[0]}. All other lead values are 0.
- R4: A normal 32-bit start is code 100 in mode 00 or code 010 in mode 10. It gives kind 7 when the half-slot's leading bits are 111, and kind 3 otherwise.
- R5: In mode 10, the codes map as follows. 000 and 001 give kind 1 with lead {0, code[0]}. 011 gives kind 0. 100 to 111 give kind 6 with lead = code[1:0].
- R6: In mode 11, every active half-slot is kind 6 with lead = code[1:0] and break = code[2]. In every other mode `brk_o` is all zero.
- R7: Mode 01 is reserved. It sets `illegal_o` to 1 and forces all start, kind, lead and break outputs to 0. In the other modes `illegal_o` is 0.
- R8: With REG_OUT = 1, outputs reflect the inputs present at the previous rising clock edge. The active-low asynchronous reset drives all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional output stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Mode selecting the prefix code meaning |
| remain_i | input | 4 | Number of half-slots left after the headers |
| pfx_i | input | 42 | Prefix fields, field 0 rightmost |
| msb_i | input | 42 | Leading three bits of each half-slot |
| start_o | output | 14 | Instruction starts in half-slot k |
| kind_o | output | 42 | Instruction kind per half-slot |
| lead_o | output | 28 | Reconstructed leading bits per half-slot |
| brk_o | output | 14 | Break flag per half-slot |
| illegal_o | output | 1 | Reserved mode selected |

## Verification
The decoder is driven with every code in every mode, including the reserved mode. This separates the mode-dependent tables and shows whether the break bits stay confined to mode 11. The 32-bit start codes are paired with leading bits of 111 and of 110, which tells a long instruction from a normal one in both modes that allow it. A sweep of the remaining count from 0 to 15 exposes misalignment between prefix fields and half-slots, and also any wrong handling of counts past the limit. Random blocks are compared against a behavioural model every cycle, and the output is read between edges to confirm the one-cycle latency.

// File: rtl/hsd_pkg.sv
package hsd_pkg;
   localparam int unsigned PFX_W  = 3;
   localparam int unsigned LEAD_W = 2;
   localparam int unsigned KIND_W = 3;
   localparam int unsigned SLOT_W = 1 + KIND_W + LEAD_W + 1;

   typedef enum logic [KIND_W-1:0] {
      K_NONE = 3'd0,
      K_S17  = 3'd1,
      K_AUG  = 3'd2,
      K_W32  = 3'd3,
      K_ALT  = 3'd4,
      K_W33  = 3'd5,
      K_S18  = 3'd6,
      K_LONG = 3'd7
   } kind_e;

   typedef enum logic [1:0] {
      M_BASE  = 2'b00,
      M_RSVD  = 2'b01,
      M_MIX18 = 2'b10,
      M_ALL18 = 2'b11
   } mode_e;
endpackage

// File: rtl/hsd_slot_dec.sv
module hsd_slot_dec
   import hsd_pkg::*;
(
   input  logic                act_i,
   input  logic [1:0]          mode_i,
   input  logic [PFX_W-1:0]    code_i,
   input  logic [2:0]          top_i,
   output logic                start_o,
   output logic [KIND_W-1:0]   kind_o,
   output logic [LEAD_W-1:0]   lead_o,
   output logic                brk_o
);
   kind_e kind;
   logic  is_long;

   assign is_long = (top_i == 3'b111);

   always_comb begin
      kind   = K_NONE;
      lead_o = '0;
      brk_o  = 1'b0;
      if (act_i) begin
         case (mode_i)
            M_BASE: begin
               case (code_i)
                  3'b000, 3'b001: begin kind = K_S17; lead_o = {1'b0, code_i[0]}; end
                  3'b010:         kind = K_AUG;
                  3'b011:         kind = K_NONE;
                  3'b100:         kind = is_long ? K_LONG : K_W32;
                  3'b101:         kind = K_ALT;
                  default:        begin kind = K_W33; lead_o = {1'b0, code_i[0]}; end
               endcase
            end
            M_MIX18: begin
               case (code_i)
                  3'b000, 3'b001: begin kind = K_S17; lead_o = {1'b0, code_i[0]}; end
                  3'b010:         kind = is_long ? K_LONG : K_W32;
                  3'b011:         kind = K_NONE;
                  default:        begin kind = K_S18; lead_o = code_i[1:0]; end
               endcase
            end
            M_ALL18: begin
               kind   = K_S18;
               lead_o = code_i[1:0];
               brk_o  = code_i[2];
            end
            default: kind = K_NONE;
         endcase
      end
   end

   assign kind_o  = kind;
   assign start_o = (kind != K_NONE);
endmodule

// File: rtl/hsd_pipe.sv
module hsd_pipe #(
   parameter int unsigned W   = 8,
   parameter bit          REG = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d_i,
   output logic [W-1:0] q_o
);
   generate
      if (REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q_o <= '0;
            else        q_o <= d_i;
         end
      end else begin : g_comb
         assign q_o = d_i;
      end
   endgenerate
endmodule

// File: rtl/hsd_prefix_decoder.sv
module hsd_prefix_decoder
   import hsd_pkg::*;
#(
   parameter int unsigned NUM_HALF = 14,
   parameter bit          REG_OUT  = 1'b1,
   localparam int unsigned CNT_W   = $clog2(NUM_HALF + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [1:0]                  mode_i,
   input  logic [CNT_W-1:0]            remain_i,
   input  logic [NUM_HALF*PFX_W-1:0]   pfx_i,
   input  logic [NUM_HALF*3-1:0]       msb_i,
   output logic [NUM_HALF-1:0]         start_o,
   output logic [NUM_HALF*KIND_W-1:0]  kind_o,
   output logic [NUM_HALF*LEAD_W-1:0]  lead_o,
   output logic [NUM_HALF-1:0]         brk_o,
   output logic                        illegal_o
);
   localparam int unsigned BUS_W = NUM_HALF * SLOT_W + 1;

   generate
      if (NUM_HALF < 1 || NUM_HALF > 14) begin : g_bad_num
         $error("hsd_prefix_decoder: NUM_HALF must be 1..14");
      end
   endgenerate

   logic             illegal;
   logic [BUS_W-1:0] bus_d, bus_q;

   assign illegal = (mode_i == M_RSVD);

   generate
      for (genvar k = 0; k < NUM_HALF; k++) begin : g_slot
         logic              act, st, bk;
         logic [KIND_W-1:0] kd;
         logic [LEAD_W-1:0] ld;

         assign act = !illegal && (CNT_W'(k) < remain_i);

         hsd_slot_dec u_dec (
            .act_i   (act),
            .mode_i  (mode_i),
            .code_i  (pfx_i[k*PFX_W +: PFX_W]),
            .top_i   (msb_i[k*3 +: 3]),
            .start_o (st),
            .kind_o  (kd),
            .lead_o  (ld),
            .brk_o   (bk)
         );

         assign bus_d[k*SLOT_W +: SLOT_W] = {bk, ld, kd, st};

         assign start_o[k]                  = bus_q[k*SLOT_W];
         assign kind_o[k*KIND_W +: KIND_W]  = bus_q[k*SLOT_W + 1 +: KIND_W];
         assign lead_o[k*LEAD_W +: LEAD_W]  = bus_q[k*SLOT_W + 1 + KIND_W +: LEAD_W];
         assign brk_o[k]                    = bus_q[k*SLOT_W + SLOT_W - 1];
      end
   endgenerate

   assign bus_d[BUS_W-1] = illegal;
   assign illegal_o      = bus_q[BUS_W-1];

   hsd_pipe #(.W(BUS_W), .REG(REG_OUT)) u_pipe (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (bus_d),
      .q_o   (bus_q)
   );
endmodule

// File: rtl/hsd_prefix_decoder_chk.sv
module hsd_prefix_decoder_chk
   import hsd_pkg::*;
#(
   parameter int unsigned NUM_HALF = 14,
   parameter bit          REG_OUT  = 1'b1,
   localparam int unsigned CNT_W   = $clog2(NUM_HALF + 1)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic [1:0]                  mode_i,
   input logic [CNT_W-1:0]            remain_i,
   input logic [NUM_HALF*PFX_W-1:0]   pfx_i,
   input logic [NUM_HALF*3-1:0]       msb_i,
   input logic [NUM_HALF-1:0]         start_o,
   input logic [NUM_HALF*KIND_W-1:0]  kind_o,
   input logic [NUM_HALF*LEAD_W-1:0]  lead_o,
   input logic [NUM_HALF-1:0]         brk_o,
   input logic                        illegal_o
);
   logic [1:0]       mode_d;
   logic [CNT_W-1:0] rem_d;

   generate
      if (REG_OUT) begin : g_d
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin mode_d <= '0; rem_d <= '0; end
            else        begin mode_d <= mode_i; rem_d <= remain_i; end
         end
      end else begin : g_nd
         assign mode_d = mode_i;
         assign rem_d  = remain_i;
      end
   endgenerate

   // R7
   a_r7_illegal_flag: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o == (mode_d == 2'b01));
   a_r7_illegal_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      illegal_o |-> (start_o == '0 && brk_o == '0 && kind_o == '0));
   // R6
   a_r6_brk_only_all18: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_d != 2'b11) |-> (brk_o == '0));

   generate
      for (genvar k = 0; k < NUM_HALF; k++) begin : g_chk
         // R1
         a_r1_beyond_count: assert property (@(posedge clk) disable iff (!rst_n)
            (CNT_W'(k) >= rem_d) |-> (!start_o[k] && kind_o[k*KIND_W +: KIND_W] == '0));
         // R6
         a_r6_all18_starts: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_d == 2'b11 && CNT_W'(k) < rem_d) |-> (start_o[k] && kind_o[k*KIND_W +: KIND_W] == 3'd6));
      end
   endgenerate
endmodule

bind hsd_prefix_decoder hsd_prefix_decoder_chk #(.NUM_HALF(NUM_HALF), .REG_OUT(REG_OUT)) u_chk (.*);

// File: tb/sim_hsd_prefix_decoder.sv
module sim_hsd_prefix_decoder;
   localparam int N = 14;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [1:0]    mode_i = '0;
   logic [3:0]    remain_i = '0;
   logic [N*3-1:0] pfx_i = '0;
   logic [N*3-1:0] msb_i = '0;
   logic [N-1:0]   start_o, brk_o;
   logic [N*3-1:0] kind_o;
   logic [N*2-1:0] lead_o;
   logic           illegal_o;

   int checks = 0;
   int errors = 0;

   logic [N-1:0]   e_start, e_brk;
   logic [N*3-1:0] e_kind;
   logic [N*2-1:0] e_lead;
   logic           e_ill;

   always #10 clk = ~clk;

   hsd_prefix_decoder u0 (
      .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .remain_i(remain_i),
      .pfx_i(pfx_i), .msb_i(msb_i), .start_o(start_o), .kind_o(kind_o),
      .lead_o(lead_o), .brk_o(brk_o), .illegal_o(illegal_o));

   // behavioural reference, computed from the requirement tables
   task automatic model();
      e_start = '0; e_kind = '0; e_lead = '0; e_brk = '0;
      e_ill = (mode_i == 2'b01);
      for (int k = 0; k < N; k++) begin
         int c, kd, ld, bk;
         bit lng;
         c = int'(pfx_i[k*3 +: 3]);
         lng = (msb_i[k*3 +: 3] == 3'b111);
         kd = 0; ld = 0; bk = 0;
         if (k < int'(remain_i) && !e_ill) begin
            if (mode_i == 2'b00) begin
               if (c < 2) begin kd = 1; ld = c; end
               else if (c == 2) kd = 2;
               else if (c == 4) kd = lng ? 7 : 3;
               else if (c == 5) kd = 4;
               else if (c >= 6) begin kd = 5; ld = c - 6; end
            end else if (mode_i == 2'b10) begin
               if (c < 2) begin kd = 1; ld = c; end
               else if (c == 2) kd = lng ? 7 : 3;
               else if (c >= 4) begin kd = 6; ld = c - 4; end
            end else begin
               kd = 6; ld = c % 4; bk = c / 4;
            end
         end
         e_kind[k*3 +: 3] = 3'(kd);
         e_lead[k*2 +: 2] = 2'(ld);
         e_brk[k]   = (bk != 0);
         e_start[k] = (kd != 0);
      end
   endtask

   task automatic cmp(string tag);
      checks++;
      if (start_o !== e_start || kind_o !== e_kind || lead_o !== e_lead ||
          brk_o !== e_brk || illegal_o !== e_ill) begin
         errors++;
         $display("FAIL %s start=%h/%h kind=%h/%h lead=%h/%h brk=%h/%h ill=%b/%b (actual/expected)",
                  tag, start_o, e_start, kind_o, e_kind, lead_o, e_lead, brk_o, e_brk, illegal_o, e_ill);
      end
   endtask

   task automatic one(string tag, int got, int exp);
      checks++;
      if (got != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", tag, got, exp);
      end
   endtask

   // apply inputs at a falling edge, let one rising edge capture them, compare at the next falling edge
   task automatic step(string tag, logic [1:0] m, logic [3:0] r, logic [N*3-1:0] p, logic [N*3-1:0] h);
      mode_i = m; remain_i = r; pfx_i = p; msb_i = h;
      @(posedge clk);
      @(negedge clk);
      model();
      cmp(tag);
   endtask

   function automatic logic [N*3-1:0] rnd42();
      return {10'($urandom), 32'($urandom)};
   endfunction

   function automatic logic [N*3-1:0] fill(logic [2:0] c);
      logic [N*3-1:0] v;
      for (int k = 0; k < N; k++) v[k*3 +: 3] = c;
      return v;
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      // R8 reset clears outputs even with busy inputs
      mode_i = 2'b11; remain_i = 4'd14; pfx_i = fill(3'b111); msb_i = fill(3'b111);
      repeat (3) @(negedge clk);
      e_start = '0; e_kind = '0; e_lead = '0; e_brk = '0; e_ill = 1'b0;
      cmp("R8 reset");
      rst_n = 1'b1;

      // R3 every code in mode 00, all half-slots active
      for (int c = 0; c < 8; c++) step("R3 mode00 code", 2'b00, 4'd14, fill(3'(c)), fill(3'b000));
      step("R3 mode00 mixed", 2'b00, 4'd14, rnd42(), rnd42());

      // R4 long versus normal 32-bit starts
      step("R4 mode00 long", 2'b00, 4'd14, fill(3'b100), fill(3'b111));
      one("R4 slot0 kind long", int'(kind_o[2:0]), 7);
      step("R4 mode00 normal", 2'b00, 4'd14, fill(3'b100), fill(3'b110));
      one("R4 slot0 kind normal", int'(kind_o[2:0]), 3);
      step("R4 mode10 long", 2'b10, 4'd14, fill(3'b010), fill(3'b111));
      one("R4 mode10 slot13 kind", int'(kind_o[41:39]), 7);
      step("R4 mode10 normal", 2'b10, 4'd14, fill(3'b010), fill(3'b011));

      // R5 every code in mode 10
      for (int c = 0; c < 8; c++) step("R5 mode10 code", 2'b10, 4'd14, fill(3'(c)), rnd42());
      step("R5 mode10 code110", 2'b10, 4'd14, fill(3'b110), '0);
      one("R5 lead code110", int'(lead_o[1:0]), 2);

      // R6 all-18 mode with break bits
      step("R6 mode11 random", 2'b11, 4'd14, rnd42(), rnd42());
      step("R6 mode11 brk", 2'b11, 4'd14, fill(3'b101), '0);
      one("R6 brk all set", int'(brk_o), 16'h3fff);
      one("R6 lead", int'(lead_o[3:2]), 1);

      // R7 reserved mode
      step("R7 reserved", 2'b01, 4'd14, fill(3'b100), fill(3'b111));
      one("R7 illegal flag", int'(illegal_o), 1);
      one("R7 no starts", int'(start_o), 0);

      // R1 right alignment and count sweep, including a count above the limit
      for (int r = 0; r < 16; r++) step("R1 count sweep", 2'b11, 4'(r), fill(3'b000), '0);
      step("R1 count3", 2'b00, 4'd3, fill(3'b100), '0);
      one("R1 count3 starts", int'(start_o), 7);

      // R8 latency: new inputs are invisible until the next rising edge
      step("R8 base", 2'b00, 4'd14, fill(3'b011), '0);
      mode_i = 2'b11; pfx_i = fill(3'b110);
      #2;
      one("R8 held before edge", int'(start_o), 0);
      @(posedge clk); @(negedge clk);
      model();
      cmp("R8 after edge");

      // R2 random blocks over all modes
      for (int i = 0; i < 400; i++)
         step("R2 random", 2'($urandom), 4'($urandom), rnd42(), rnd42());

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule